// File: doc/BRIEF.md
# One-Time Fuse Array Controller

This block manages a one-time-programmable fuse array that is modelled in the block as a register array. The array has several banks, and each bank holds a number of 8-bit words. A simple synchronous register bus reaches the block's control and status registers and a window of shadow words. Software picks a target by writing a bank, row and bit index into two byte-wide address registers. It then starts one of two cycles from the control register. A program cycle burns one addressed fuse bit. A sense cycle copies one fuse word into the sense-data register.

Programming needs a key. The key register must hold 0xAA when the command is accepted, and writing any other value (normally 0x00) locks programming again. One-way lock registers protect whole banks: one lock blocks programming, one blocks overriding shadow words, and one blocks reading. Completion flags and error flags are sticky, and software clears them by writing 1 to each bit. Two mask registers choose which flags drive a single interrupt line. A write into the shadow window replaces the value that later reads of that word return. The burned fuses are not changed by such a write.

Register offsets: 0 status, 1 status mask, 2 error, 3 error mask, 4 control, 5 upper address, 6 lower address, 7 sense data, 8 program key, 9 program lock, 10 override lock, 11 read lock. The shadow word for bank b and row r sits at address SHADOW_BASE + b*WORDS_PER_BANK + r.

Top module: `otp_fuse_ctrl`

## Requirements
- R1: After reset the status, error, control, sense-data and key registers read 0, the interrupt output is low, and every shadow word reads 0.
- R2: Writing control bit 0 while the key register holds 0xAA, the bank's program-lock bit is clear and the address is in range holds status bit 7 (busy) high for exactly PROG_CYC cycles. After that, only the addressed fuse bit is set and status bit 1 (program done) is set. The bank is upper[5:3], the row is {upper[2:0], lower[7:3]} and the bit is lower[2:0]. A byte is burned with one command per set bit.
- R3: A program command issued when the key is not 0xAA (for example after 0x00 is written to the key register), or issued to a bank whose bit is set in the program-lock register, sets error bit 6. It does not start a cycle and leaves the fuses unchanged.
- R4: A program command whose bank or row is out of range sets error bit 7 and changes nothing.
- R5: Control bit 3 (with bit 0 clear) starts a sense cycle that holds busy high for exactly SENSE_CYC cycles. The cycle then loads the raw fuse word into the sense-data register and sets status bit 0 (sense done). Shadow overrides do not affect the sensed value.
- R6: A sense command to a read-locked bank or to an out-of-range row sets error bit 2, starts no cycle and leaves the sense-data register unchanged.
- R7: A write to a shadow word of a bank that is not override-locked makes reads of that word return the written value. When the bank is override-locked, the write sets error bit 5 and the word keeps its value.
- R8: A bus read of a shadow word in a read-locked bank returns 0 and sets error bit 4.
- R9: Status bits 1:0 and the error bits are sticky, and writing 1 to a bit clears it.
- R10: The interrupt output is high exactly when some status bit is set together with its bit in the status mask, or some error bit is set together with its bit in the error mask.
- R11: A write to the control register while busy is ignored: no cycle starts and the stored control value does not change.
- R12: The three lock registers only gain bits. Writing 0 to a lock bit leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, qualifies read side effects |
| bus_addr | input | ADDR_W | Register or shadow-window address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| irq | output | 1 | Masked flag interrupt |

## Verification
The assertions take for granted that the two address registers stay unchanged between accepting a command and reading its outcome. They also assume that bus_wr and bus_rd are never high in the same cycle, and that NUM_BANKS fits the 3-bit bank field. The stimulus meets these conditions. Each bus access is one strobe cycle, driven on the falling clock edge. Every command waits until busy has dropped before the address registers are rewritten, except in the deliberate busy-collision case, which leaves them unchanged. The fuse assertions also depend on the key being seen at the edge where a program command is accepted, and the bench always writes the key before it issues the command.

// File: rtl/otp_pkg.sv
// Package: shared register offsets and flag bit positions for the fuse
// controller. Assumes an 8-bit data bus and a 3-bit bank field.
package otp_pkg;
    localparam int DATA_W       = 8;
    localparam int BANK_FIELD_W = 3;
    localparam int LOCK_W       = 8;

    localparam int OFF_STAT  = 0;
    localparam int OFF_STATM = 1;
    localparam int OFF_ERR   = 2;
    localparam int OFF_EMASK = 3;
    localparam int OFF_CTRL  = 4;
    localparam int OFF_UADDR = 5;
    localparam int OFF_LADDR = 6;
    localparam int OFF_SDATA = 7;
    localparam int OFF_KEY   = 8;
    localparam int OFF_PLOCK = 9;
    localparam int OFF_OLOCK = 10;
    localparam int OFF_RLOCK = 11;

    localparam logic [DATA_W-1:0] UNLOCK_KEY = 8'hAA;

    // status flag positions (busy is live, not sticky)
    localparam int ST_BUSY  = 7;
    localparam int ST_PDONE = 1;
    localparam int ST_SDONE = 0;

    // error flag positions
    localparam int ER_PROG  = 7;
    localparam int ER_WPROT = 6;
    localparam int ER_OPROT = 5;
    localparam int ER_RPROT = 4;
    localparam int ER_SENSE = 2;

    // control bits
    localparam int CT_PROG  = 0;
    localparam int CT_SENSE = 3;
    localparam logic [DATA_W-1:0] CT_KEEP_MASK = 8'hF6;
endpackage

// File: rtl/otp_cycle_seq.sv
// Module: cycle sequencer. Runs one program or sense cycle of fixed length
// and pulses the matching done output on its last busy cycle.
// Assumes start requests arrive only while idle; program wins a tie.
module otp_cycle_seq #(
    parameter int PROG_CYC  = 16,
    parameter int SENSE_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_prog,
    input  logic start_sense,
    output logic busy,
    output logic is_prog,
    output logic done_prog,
    output logic done_sense
);
    localparam int MAX_CYC = (PROG_CYC > SENSE_CYC) ? PROG_CYC : SENSE_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    logic [CNT_W-1:0] cnt_q;

    // Load, count down and retire the active cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            is_prog <= 1'b0;
            cnt_q   <= '0;
        end else if (busy) begin
            if (cnt_q == '0) begin
                busy <= 1'b0;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end else if (start_prog) begin
            busy    <= 1'b1;
            is_prog <= 1'b1;
            cnt_q   <= CNT_W'(PROG_CYC - 1);
        end else if (start_sense) begin
            busy    <= 1'b1;
            is_prog <= 1'b0;
            cnt_q   <= CNT_W'(SENSE_CYC - 1);
        end
    end

    // Flag the final cycle of each kind.
    always_comb begin
        done_prog  = busy && (cnt_q == '0) && is_prog;
        done_sense = busy && (cnt_q == '0) && !is_prog;
    end

    AST_CNT_WITHIN_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cnt_q <= (is_prog ? CNT_W'(PROG_CYC - 1) : CNT_W'(SENSE_CYC - 1)))); // R2
    AST_NO_START_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !(start_prog || start_sense)); // R11
endmodule

// File: rtl/otp_fuse_store.sv
// Module: fuse array model with per-word shadow overrides.
// Fuse bits only ever go from 0 to 1, one bit per program pulse. The window
// port returns the override value when one exists, else the fuse word; the
// sense port always returns the raw fuse word.
module otp_fuse_store #(
    parameter int TOTAL_WORDS = 128,
    parameter int IDX_W       = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             prog_en,
    input  logic [IDX_W-1:0] prog_idx,
    input  logic [2:0]       prog_bit,
    input  logic             ovr_en,
    input  logic [IDX_W-1:0] ovr_idx,
    input  logic [7:0]       ovr_data,
    input  logic [IDX_W-1:0] sns_idx,
    output logic [7:0]       sns_word,
    input  logic [IDX_W-1:0] win_idx,
    output logic [7:0]       win_word
);
    localparam int FLAT_W = TOTAL_WORDS * 8;

    logic [7:0]             fuse_q [TOTAL_WORDS];
    logic [7:0]             ovr_q  [TOTAL_WORDS];
    logic [TOTAL_WORDS-1:0] ovr_vld_q;
    logic [FLAT_W-1:0]      fuse_flat;

    // Burn the addressed fuse bit at the end of a program cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < TOTAL_WORDS; w++) fuse_q[w] <= '0;
        end else if (prog_en) begin
            fuse_q[prog_idx][prog_bit] <= 1'b1;
        end
    end

    // Capture shadow overrides written over the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovr_vld_q <= '0;
            for (int w = 0; w < TOTAL_WORDS; w++) ovr_q[w] <= '0;
        end else if (ovr_en) begin
            ovr_vld_q[ovr_idx] <= 1'b1;
            ovr_q[ovr_idx]     <= ovr_data;
        end
    end

    // Read ports: raw for sensing, override-aware for the window.
    always_comb begin
        sns_word = fuse_q[sns_idx];
        win_word = ovr_vld_q[win_idx] ? ovr_q[win_idx] : fuse_q[win_idx];
    end

    // Flatten the array for whole-array checks.
    always_comb begin
        for (int w = 0; w < TOTAL_WORDS; w++) fuse_flat[w*8 +: 8] = fuse_q[w];
    end

    AST_FUSE_NEVER_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(fuse_flat) & ~fuse_flat) == '0); // R2
    AST_ONE_BIT_PER_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(fuse_flat ^ $past(fuse_flat)) <= 1); // R2
endmodule

// File: rtl/otp_flag_regs.sv
// Module: sticky flag register with write-1-to-clear and interrupt masking.
// A bit that is set and cleared in the same cycle stays set.
module otp_flag_regs #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_bits,
    input  logic         clr_en,
    input  logic [W-1:0] clr_bits,
    input  logic [W-1:0] mask,
    output logic [W-1:0] flags,
    output logic         any_masked
);
    logic [W-1:0] clr_vec;

    // Select the bits cleared this cycle.
    always_comb clr_vec = clr_en ? clr_bits : '0;

    // Hold flags until cleared by a write of 1.
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flags & ~clr_vec) | set_bits;
    end

    // Reduce masked flags to one request.
    always_comb any_masked = |(flags & mask);

    for (genvar i = 0; i < W; i++) begin : g_sticky
        AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(flags[i]) && !($past(clr_en) && $past(clr_bits[i]))) |-> flags[i]); // R9
    end
endmodule

// File: rtl/otp_fuse_ctrl.sv
// Module: register-mapped one-time fuse controller (top).
// Decodes the register bus, checks key, locks and address range on each
// command, and sequences program and sense cycles on the fuse store.
// Assumes one bus strobe per cycle and NUM_BANKS no larger than 8.
module otp_fuse_ctrl #(
    parameter int NUM_BANKS      = 8,
    parameter int WORDS_PER_BANK = 16,
    parameter int PROG_CYC       = 16,
    parameter int SENSE_CYC      = 4,
    parameter int ADDR_W         = 9,
    parameter int SHADOW_BASE    = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              irq
);
    import otp_pkg::*;

    localparam int TOTAL = NUM_BANKS * WORDS_PER_BANK;
    localparam int IDX_W = (TOTAL > 1) ? $clog2(TOTAL) : 1;
    localparam int BW    = BANK_FIELD_W;

    logic [7:0]        stmask_q, ermask_q, ctrl_q, uaddr_q, laddr_q, sdata_q, key_q;
    logic [LOCK_W-1:0] plock_q, olock_q, rlock_q;
    logic [IDX_W-1:0]  lat_idx;
    logic [2:0]        lat_bit;

    logic              seq_busy, seq_is_prog, done_prog, done_sense;
    logic              start_prog, start_sense;
    logic [7:0]        sns_word, win_word;
    logic [1:0]        st_flags, st_set;
    logic [7:0]        er_flags, er_set;
    logic              st_any, er_any;

    logic              wr_hit_stat, wr_hit_err, wr_hit_ctrl;
    logic              ctrl_acc, prog_try, sense_try;
    logic [BW-1:0]     cmd_bank, win_bank;
    logic [7:0]        cmd_row;
    logic [2:0]        cmd_bit;
    logic              cmd_in_range;
    logic [IDX_W-1:0]  cmd_idx, win_idx;
    logic [ADDR_W-1:0] win_off;
    logic              win_hit, ovr_try, rd_win;

    // Decode the bus address into register and window hits.
    always_comb begin
        wr_hit_stat = bus_wr && (bus_addr == ADDR_W'(OFF_STAT));
        wr_hit_err  = bus_wr && (bus_addr == ADDR_W'(OFF_ERR));
        wr_hit_ctrl = bus_wr && (bus_addr == ADDR_W'(OFF_CTRL));
        win_hit     = (bus_addr >= ADDR_W'(SHADOW_BASE)) &&
                      (bus_addr <  ADDR_W'(SHADOW_BASE + TOTAL));
        win_off     = bus_addr - ADDR_W'(SHADOW_BASE);
        win_idx     = win_off[IDX_W-1:0];
        win_bank    = BW'(win_idx / IDX_W'(WORDS_PER_BANK));
        ovr_try     = bus_wr && win_hit;
        rd_win      = bus_rd && win_hit;
    end

    // Split the two address registers into bank, row and bit.
    always_comb begin
        cmd_bank     = uaddr_q[5:3];
        cmd_row      = {uaddr_q[2:0], laddr_q[7:3]};
        cmd_bit      = laddr_q[2:0];
        cmd_in_range = (int'(cmd_bank) < NUM_BANKS) && (int'(cmd_row) < WORDS_PER_BANK);
        cmd_idx      = IDX_W'(int'(cmd_bank) * WORDS_PER_BANK + int'(cmd_row));
    end

    // Qualify control writes and decide which cycle, if any, starts.
    always_comb begin
        ctrl_acc    = wr_hit_ctrl && !seq_busy;
        prog_try    = ctrl_acc && bus_wdata[CT_PROG];
        sense_try   = ctrl_acc && bus_wdata[CT_SENSE] && !bus_wdata[CT_PROG];
        start_prog  = prog_try && cmd_in_range && (key_q == UNLOCK_KEY) && !plock_q[cmd_bank];
        start_sense = sense_try && cmd_in_range && !rlock_q[cmd_bank];
    end

    // Build the error set vector from refused commands and accesses.
    always_comb begin
        er_set           = '0;
        er_set[ER_PROG]  = prog_try && !cmd_in_range;
        er_set[ER_WPROT] = prog_try && cmd_in_range && ((key_q != UNLOCK_KEY) || plock_q[cmd_bank]);
        er_set[ER_OPROT] = ovr_try && olock_q[win_bank];
        er_set[ER_RPROT] = rd_win && rlock_q[win_bank];
        er_set[ER_SENSE] = sense_try && (!cmd_in_range || rlock_q[cmd_bank]);
        st_set           = {done_prog, done_sense};
    end

    // Plain writable registers: masks, address, key.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stmask_q <= '0;
            ermask_q <= '0;
            uaddr_q  <= '0;
            laddr_q  <= '0;
            key_q    <= '0;
        end else if (bus_wr) begin
            if (bus_addr == ADDR_W'(OFF_STATM)) stmask_q <= bus_wdata;
            if (bus_addr == ADDR_W'(OFF_EMASK)) ermask_q <= bus_wdata;
            if (bus_addr == ADDR_W'(OFF_UADDR)) uaddr_q  <= bus_wdata;
            if (bus_addr == ADDR_W'(OFF_LADDR)) laddr_q  <= bus_wdata;
            if (bus_addr == ADDR_W'(OFF_KEY))   key_q    <= bus_wdata;
        end
    end

    // One-way lock registers: writes only add bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            plock_q <= '0;
            olock_q <= '0;
            rlock_q <= '0;
        end else if (bus_wr) begin
            if (bus_addr == ADDR_W'(OFF_PLOCK)) plock_q <= plock_q | bus_wdata;
            if (bus_addr == ADDR_W'(OFF_OLOCK)) olock_q <= olock_q | bus_wdata;
            if (bus_addr == ADDR_W'(OFF_RLOCK)) rlock_q <= rlock_q | bus_wdata;
        end
    end

    // Control register keeps its non-start bits from accepted writes.
    always_ff @(posedge clk) begin
        if (!rst_n)        ctrl_q <= '0;
        else if (ctrl_acc) ctrl_q <= bus_wdata & CT_KEEP_MASK;
    end

    // Latch the command target when a cycle starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_idx <= '0;
            lat_bit <= '0;
        end else if (start_prog || start_sense) begin
            lat_idx <= cmd_idx;
            lat_bit <= cmd_bit;
        end
    end

    // Capture the sensed word at the end of a sense cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)          sdata_q <= '0;
        else if (done_sense) sdata_q <= sns_word;
    end

    otp_cycle_seq #(
        .PROG_CYC  (PROG_CYC),
        .SENSE_CYC (SENSE_CYC)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_prog  (start_prog),
        .start_sense (start_sense),
        .busy        (seq_busy),
        .is_prog     (seq_is_prog),
        .done_prog   (done_prog),
        .done_sense  (done_sense)
    );

    otp_fuse_store #(
        .TOTAL_WORDS (TOTAL),
        .IDX_W       (IDX_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .prog_en  (done_prog),
        .prog_idx (lat_idx),
        .prog_bit (lat_bit),
        .ovr_en   (ovr_try && !olock_q[win_bank]),
        .ovr_idx  (win_idx),
        .ovr_data (bus_wdata),
        .sns_idx  (lat_idx),
        .sns_word (sns_word),
        .win_idx  (win_idx),
        .win_word (win_word)
    );

    otp_flag_regs #(.W(2)) u_stat_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_bits   (st_set),
        .clr_en     (wr_hit_stat),
        .clr_bits   (bus_wdata[1:0]),
        .mask       (stmask_q[1:0]),
        .flags      (st_flags),
        .any_masked (st_any)
    );

    otp_flag_regs #(.W(8)) u_err_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_bits   (er_set),
        .clr_en     (wr_hit_err),
        .clr_bits   (bus_wdata),
        .mask       (ermask_q),
        .flags      (er_flags),
        .any_masked (er_any)
    );

    // Combine the masked flag requests.
    always_comb irq = st_any || er_any;

    // Read data multiplexer.
    always_comb begin
        bus_rdata = '0;
        if (win_hit) begin
            bus_rdata = rlock_q[win_bank] ? 8'h00 : win_word;
        end else begin
            case (int'(bus_addr))
                OFF_STAT:  bus_rdata = {seq_busy, 5'b0, st_flags};
                OFF_STATM: bus_rdata = stmask_q;
                OFF_ERR:   bus_rdata = er_flags;
                OFF_EMASK: bus_rdata = ermask_q;
                OFF_CTRL:  bus_rdata = ctrl_q;
                OFF_UADDR: bus_rdata = uaddr_q;
                OFF_LADDR: bus_rdata = laddr_q;
                OFF_SDATA: bus_rdata = sdata_q;
                OFF_KEY:   bus_rdata = key_q;
                OFF_PLOCK: bus_rdata = plock_q;
                OFF_OLOCK: bus_rdata = olock_q;
                OFF_RLOCK: bus_rdata = rlock_q;
                default:   bus_rdata = '0;
            endcase
        end
    end

    AST_PROG_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(seq_busy) && seq_is_prog) |-> ($past(key_q) == UNLOCK_KEY)); // R3
    AST_CYCLE_FROM_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seq_busy) |-> $past(wr_hit_ctrl)); // R5
    AST_SDATA_ONLY_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(done_sense) |-> $stable(sdata_q)); // R6
    AST_LOCKS_ONE_WAY: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(plock_q) & ~plock_q) == '0) && (($past(rlock_q) & ~rlock_q) == '0)); // R12
endmodule

// File: tb/otp_fuse_ctrl_tb.sv
module otp_fuse_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int PROG_CYC   = 16;
    localparam int SENSE_CYC  = 4;
    localparam int WPB        = 16;
    localparam int BASE       = 256;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [8:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    otp_fuse_ctrl #(
        .NUM_BANKS(8), .WORDS_PER_BANK(WPB), .PROG_CYC(PROG_CYC),
        .SENSE_CYC(SENSE_CYC), .ADDR_W(9), .SHADOW_BASE(BASE)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        bus_addr = 9'(a); bus_wdata = 8'(d); bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, output int d);
        @(negedge clk);
        bus_addr = 9'(a); bus_rd = 1'b1;
        #1 d = int'(bus_rdata);
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic peek(input int a, output int d);
        bus_addr = 9'(a);
        #1 d = int'(bus_rdata);
    endtask

    // Returns the number of sampled cycles with busy high.
    task automatic wait_idle(output int n);
        int s;
        n = 0;
        peek(0, s);
        while (s[7] && n < 1000) begin
            n++;
            @(posedge clk); #1;
            peek(0, s);
        end
    endtask

    task automatic set_addr(input int bank, input int row, input int bitn);
        wr(5, (bank << 3) | (row >> 5));
        wr(6, ((row << 3) | bitn) & 8'hFF);
    endtask

    task automatic prog_bit(input int bank, input int row, input int bitn, output int n);
        set_addr(bank, row, bitn);
        wr(4, 8'h01);
        wait_idle(n);
    endtask

    task automatic t_reset();
        int d;
        rd(0, d);  chk("R1 status", d, 0);
        rd(2, d);  chk("R1 error", d, 0);
        rd(4, d);  chk("R1 control", d, 0);
        rd(7, d);  chk("R1 sense data", d, 0);
        rd(8, d);  chk("R1 key", d, 0);
        rd(BASE + 5*WPB + 9, d); chk("R1 shadow", d, 0);
        chk("R1 irq", int'(irq), 0);
    endtask

    task automatic t_program();
        int d, n;
        wr(8, 8'hAA);
        prog_bit(2, 5, 3, n);
        chk("R2 busy length", n, PROG_CYC);
        rd(BASE + 2*WPB + 5, d); chk("R2 single bit", d, 8'h08);
        rd(0, d); chk("R2 prog done", d, 8'h02);
        prog_bit(2, 5, 0, n);
        rd(BASE + 2*WPB + 5, d); chk("R2 second bit", d, 8'h09);
        rd(BASE + 2*WPB + 4, d); chk("R2 neighbour untouched", d, 0);
        wr(0, 8'h02);
        rd(0, d); chk("R9 status cleared", d, 0);
        // burn 0xA5 lowest bit first into last row of last bank
        for (int b = 0; b < 8; b++) begin
            if (((8'hA5 >> b) & 1) != 0) prog_bit(7, WPB-1, b, n);
        end
        rd(BASE + 7*WPB + WPB-1, d); chk("R2 byte burn", d, 8'hA5);
        wr(0, 8'h03);
    endtask

    task automatic t_protect();
        int d, n;
        wr(8, 8'h00);
        prog_bit(2, 5, 7, n);
        chk("R3 no busy without key", n, 0);
        rd(2, d); chk("R3 wprot error", d, 8'h40);
        rd(BASE + 2*WPB + 5, d); chk("R3 fuse unchanged", d, 8'h09);
        wr(2, 8'h40);
        rd(2, d); chk("R9 error cleared", d, 0);
        wr(9, 8'h02);
        wr(8, 8'hAA);
        prog_bit(1, 0, 0, n);
        rd(2, d); chk("R3 bank lock error", d, 8'h40);
        rd(BASE + 1*WPB, d); chk("R3 locked bank unchanged", d, 0);
        wr(9, 8'h00);
        rd(9, d); chk("R12 lock kept", d, 8'h02);
        wr(2, 8'hFF);
        prog_bit(0, WPB, 0, n);
        rd(2, d); chk("R4 range error", d, 8'h80);
        chk("R4 no busy", n, 0);
        rd(0, d); chk("R4 no done", d, 0);
        wr(2, 8'hFF);
    endtask

    task automatic t_sense();
        int d, n;
        set_addr(2, 5, 0);
        wr(4, 8'h08);
        wait_idle(n);
        chk("R5 busy length", n, SENSE_CYC);
        rd(7, d); chk("R5 sense data", d, 8'h09);
        rd(0, d); chk("R5 sense done", d, 8'h01);
        wr(0, 8'h01);
        wr(11, 8'h04);
        wr(4, 8'h08);
        wait_idle(n);
        chk("R6 no busy", n, 0);
        rd(2, d); chk("R6 sense error", d, 8'h04);
        rd(7, d); chk("R6 sense data kept", d, 8'h09);
        wr(2, 8'hFF);
        set_addr(0, WPB, 0);
        wr(4, 8'h08);
        rd(2, d); chk("R6 range sense error", d, 8'h04);
        wr(2, 8'hFF);
        rd(BASE + 2*WPB + 5, d); chk("R8 locked read zero", d, 0);
        rd(2, d); chk("R8 rprot error", d, 8'h10);
        wr(2, 8'hFF);
    endtask

    task automatic t_override();
        int d, n;
        wr(BASE + 3*WPB + 1, 8'h5A);
        rd(BASE + 3*WPB + 1, d); chk("R7 override read", d, 8'h5A);
        rd(2, d); chk("R7 no error", d, 0);
        set_addr(3, 1, 0);
        wr(4, 8'h08);
        wait_idle(n);
        rd(7, d); chk("R5 sense ignores override", d, 0);
        wr(0, 8'h03);
        wr(10, 8'h10);
        wr(BASE + 4*WPB + 2, 8'h33);
        rd(BASE + 4*WPB + 2, d); chk("R7 locked override kept", d, 0);
        rd(2, d); chk("R7 oprot error", d, 8'h20);
        wr(2, 8'hFF);
    endtask

    task automatic t_irq();
        int d, n;
        wr(3, 8'h40);
        #1 chk("R10 irq idle", int'(irq), 0);
        wr(8, 8'h00);
        prog_bit(0, 0, 0, n);
        #1 chk("R10 irq on masked error", int'(irq), 1);
        wr(2, 8'h40);
        #1 chk("R10 irq after clear", int'(irq), 0);
        wr(3, 8'h00);
        wr(1, 8'h01);
        set_addr(0, 0, 0);
        wr(4, 8'h08);
        wait_idle(n);
        #1 chk("R10 irq on sense done", int'(irq), 1);
        wr(0, 8'h01);
        wr(1, 8'h00);
        #1 chk("R10 irq off", int'(irq), 0);
    endtask

    task automatic t_busy_ignore();
        int d, n;
        wr(8, 8'hAA);
        set_addr(0, 0, 6);
        wr(4, 8'h08);
        wr(4, 8'h71);
        wait_idle(n);
        rd(4, d); chk("R11 control unchanged", d, 0);
        rd(0, d); chk("R11 no program done", d, 8'h01);
        rd(BASE, d); chk("R11 fuse untouched", d, 0);
        wr(0, 8'h03);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                errors++;
                $display("FAIL watchdog actual=%0d expected=done", cycles);
                $display("  CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_program();
        t_protect();
        t_sense();
        t_override();
        t_irq();
        t_busy_ignore();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule